// File: doc/BRIEF.md
# Serial Audio Output Port

This block turns stereo sample pairs into a single serial data stream. The bit clock, the left/right frame clock and an optional word clock all come from outside and are brought into the block's system clock through a bank of synchronizers. The sample source hands over a left and a right word with a valid/ready handshake. Each channel word goes out most significant bit first, in its own half of the frame.

Three run-time options shape the output timing. The first is the bit-clock edge on which data changes. The second is the framing source: any edge of the left/right clock, or the rising edge of the word clock. The third adds one bit-clock period of delay before the first data bit, as some serial audio formats need. A mute input forces the stream to zero, which is midscale in two's complement. A status output repeats an overlap flag from the sample buffer upstream.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, and until the first launch after it rises, `sdata_o` is 0, `smp_ready_o` is 1 and `mute_stat_o` is 0. The held pair is zero at reset.
- R2: `inv_bclk_i`=0 selects the falling bit-clock edge as the launch edge, so data is stable across rising edges. `inv_bclk_i`=1 selects the rising edge. `sdata_o` changes only SYNC_STAGES+1 system clocks after a launch edge at the pin, and holds between launches.
- R3: With `trig_lr_i`=1, every transition of `lrclk_i` starts a channel word. In that mode `wclk_i` has no effect.
- R4: With `trig_lr_i`=0, only a rising edge of `wclk_i` starts a channel word. In that mode `lrclk_i` transitions start nothing, and the level of `lrclk_i` picks the channel.
- R5: With `msb_late_i`=0, the MSB goes out on the first launch edge at or after the word start. With `msb_late_i`=1, that launch sends 0 and the MSB follows on the next launch.
- R6: A word has W bits, sent MSB first. Every later launch in the slot sends 0. The left word goes out while `lrclk_i` is 1 and the right word while it is 0.
- R7: A launch taken while `mute_i`=1 drives `sdata_o` to 0.
- R8: `mute_stat_o` equals `ovlp_i` delayed by one system clock. 1 means overlap, or invalid data; 0 means normal operation.
- R9: `smp_ready_o` is 1 when the one-pair holding register is empty. An accepted pair drops `smp_ready_o` on the next clock. Valid while not ready is ignored. The held pair is sent from the next left-word start, which empties the holding register.
- R10: If no pair is held at a left-word start, the previous pair is sent again.
- R11: The three option inputs are captured on each rising edge of `lrclk_i`. Changes at any other time do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | Frame clock, 1 = left slot |
| wclk_i | input | 1 | Word clock, rising edge marks a word start |
| inv_bclk_i | input | 1 | Launch edge select, 0 = falling |
| trig_lr_i | input | 1 | Framing source, 1 = frame clock edges |
| msb_late_i | input | 1 | One bit-clock delay of the MSB |
| mute_i | input | 1 | Force serial output to zero |
| ovlp_i | input | 1 | Buffer overlap flag from upstream |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Holding register free |
| smp_left_i | input | W | Left sample |
| smp_right_i | input | W | Right sample |
| sdata_o | output | 1 | Serial data |
| mute_stat_o | output | 1 | Registered overlap status |

## Verification
The assertions check on every cycle that the serial output changes only on a launch cycle and that a muted launch yields zero. They also check that the status output follows the overlap flag, and that the ready signal falls after an acceptance and stays low until a left-word start. Only the bench scenarios can show the bit order, the channel placement, the offset from each framing source, the MSB delay, the repeat of an old pair, and that a mid-frame option change waits for the next frame. Those scenarios compare every captured bit with a model of the frame.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;
   // Per-frame option set
   typedef struct packed {
      logic inv_bclk;   // 1: launch on rising bit-clock edge
      logic trig_lr;    // 1: frame-clock edges start words
      logic msb_late;   // 1: one bit-clock gap before MSB
   } ser_cfg_t;
endpackage

// File: rtl/aud_ser_sync.sv
`timescale 1ns/1ps
module aud_ser_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("aud_ser_sync: STAGES must be at least 1");
      end
      if (N < 1) begin : g_bad_width
         $error("aud_ser_sync: N must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/aud_ser_frame.sv
`timescale 1ns/1ps
module aud_ser_frame
   import aud_ser_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lr_lvl_i,
   input  logic         lr_rise_i,
   input  logic         lr_any_i,
   input  logic         w_rise_i,
   input  ser_cfg_t     cfg_i,
   input  logic         smp_valid_i,
   input  logic [W-1:0] left_i,
   input  logic [W-1:0] right_i,
   output logic         smp_ready_o,
   output ser_cfg_t     cfg_eff_o,
   output logic         word_start_o,
   output logic         left_start_o,
   output logic [W-1:0] word_data_o
);
   ser_cfg_t     cfg_act;
   logic         full;
   logic [W-1:0] pend_l, pend_r, act_l, act_r;

   // Options are frozen at each frame boundary (rising frame clock)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_act <= '0;
      else if (lr_rise_i) cfg_act <= cfg_i;
   end

   assign cfg_eff_o    = lr_rise_i ? cfg_i : cfg_act;
   assign word_start_o = cfg_eff_o.trig_lr ? lr_any_i : w_rise_i;
   assign left_start_o = word_start_o & lr_lvl_i;
   assign smp_ready_o  = ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full   <= 1'b0;
         pend_l <= '0;
         pend_r <= '0;
         act_l  <= '0;
         act_r  <= '0;
      end else if (left_start_o && full) begin
         act_l <= pend_l;
         act_r <= pend_r;
         full  <= 1'b0;
      end else if (smp_valid_i && !full) begin
         pend_l <= left_i;
         pend_r <= right_i;
         full   <= 1'b1;
      end
   end

   always_comb begin
      if (left_start_o) word_data_o = full ? pend_l : act_l;
      else              word_data_o = act_r;
   end
endmodule

// File: rtl/aud_ser_shift.sv
`timescale 1ns/1ps
module aud_ser_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         launch_i,
   input  logic         load_i,
   input  logic         late_i,
   input  logic         mute_i,
   input  logic [W-1:0] data_i,
   output logic         sdata_o
);
   localparam int SHW = W + 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("aud_ser_shift: W must be at least 2");
      end
   endgenerate

   logic [SHW-1:0] sh, ld;

   // Extra slot carries the optional one-bit gap before the MSB
   assign ld = late_i ? {1'b0, data_i} : {data_i, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         sdata_o <= 1'b0;
      end else if (load_i) begin
         if (launch_i) begin
            sdata_o <= ~mute_i & ld[SHW-1];
            sh      <= {ld[SHW-2:0], 1'b0};
         end else begin
            sh <= ld;
         end
      end else if (launch_i) begin
         sdata_o <= ~mute_i & sh[SHW-1];
         sh      <= {sh[SHW-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
   import aud_ser_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bclk_i,
   input  logic         lrclk_i,
   input  logic         wclk_i,
   input  logic         inv_bclk_i,
   input  logic         trig_lr_i,
   input  logic         msb_late_i,
   input  logic         mute_i,
   input  logic         ovlp_i,
   input  logic         smp_valid_i,
   output logic         smp_ready_o,
   input  logic [W-1:0] smp_left_i,
   input  logic [W-1:0] smp_right_i,
   output logic         sdata_o,
   output logic         mute_stat_o
);
   localparam int NSIG = 3;
   localparam int IB = 0, IL = 1, IW = 2;

   logic [NSIG-1:0] s, s_q;
   logic            b_rise, b_fall, lr_rise, lr_any, w_rise;
   logic            launch, word_start, left_start;
   logic [W-1:0]    word_data;
   ser_cfg_t        cfg_in, cfg_eff;

   aud_ser_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d_i ({wclk_i, lrclk_i, bclk_i}),
      .q_o (s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q         <= '0;
         mute_stat_o <= 1'b0;
      end else begin
         s_q         <= s;
         mute_stat_o <= ovlp_i;
      end
   end

   assign b_rise  =  s[IB] & ~s_q[IB];
   assign b_fall  = ~s[IB] &  s_q[IB];
   assign lr_rise =  s[IL] & ~s_q[IL];
   assign lr_any  =  s[IL] ^  s_q[IL];
   assign w_rise  =  s[IW] & ~s_q[IW];

   assign cfg_in = '{inv_bclk: inv_bclk_i, trig_lr: trig_lr_i, msb_late: msb_late_i};

   aud_ser_frame #(.W(W)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .lr_lvl_i     (s[IL]),
      .lr_rise_i    (lr_rise),
      .lr_any_i     (lr_any),
      .w_rise_i     (w_rise),
      .cfg_i        (cfg_in),
      .smp_valid_i  (smp_valid_i),
      .left_i       (smp_left_i),
      .right_i      (smp_right_i),
      .smp_ready_o  (smp_ready_o),
      .cfg_eff_o    (cfg_eff),
      .word_start_o (word_start),
      .left_start_o (left_start),
      .word_data_o  (word_data)
   );

   assign launch = cfg_eff.inv_bclk ? b_rise : b_fall;

   aud_ser_shift #(.W(W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .load_i   (word_start),
      .late_i   (cfg_eff.msb_late),
      .mute_i   (mute_i),
      .data_i   (word_data),
      .sdata_o  (sdata_o)
   );
endmodule

// File: rtl/aud_ser_tx_chk.sv
`timescale 1ns/1ps
module aud_ser_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic launch_i,
   input logic left_start_i,
   input logic mute_i,
   input logic ovlp_i,
   input logic sdata_i,
   input logic mute_stat_i,
   input logic valid_i,
   input logic ready_i
);
   AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_i |=> $stable(sdata_i));                              // R2
   AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && mute_i) |=> !sdata_i);                           // R7
   AST_STAT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (mute_stat_i == $past(ovlp_i)));                    // R8
   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ready_i) |=> !ready_i);                           // R9
   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_i && !left_start_i) |=> !ready_i);                    // R9
endmodule

bind aud_ser_tx aud_ser_tx_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .launch_i     (launch),
   .left_start_i (left_start),
   .mute_i       (mute_i),
   .ovlp_i       (ovlp_i),
   .sdata_i      (sdata_o),
   .mute_stat_i  (mute_stat_o),
   .valid_i      (smp_valid_i),
   .ready_i      (smp_ready_o)
);

// File: tb/aud_ser_tx_tb_top.sv
`timescale 1ns/1ps
module aud_ser_tx_tb_top;
   localparam int W    = 16;
   localparam int SLOT = 20;   // bit clocks per channel slot
   localparam int WOFS = 3;    // word-clock pulse position in a slot
   localparam int H    = 6;    // system clocks per bit-clock half
   localparam int NF   = 40;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic bclk_i = 1'b1, lrclk_i = 1'b0, wclk_i = 1'b0;
   logic inv_bclk_i = 1'b0, trig_lr_i = 1'b1, msb_late_i = 1'b0;
   logic mute_i = 1'b0, ovlp_i = 1'b0, smp_valid_i = 1'b0;
   logic [W-1:0] smp_left_i = '0, smp_right_i = '0;
   logic smp_ready_o, sdata_o, mute_stat_o;

   aud_ser_tx #(.W(W), .SYNC_STAGES(2)) dut_i (
      .clk (clk), .rst_n (rst_n), .bclk_i (bclk_i), .lrclk_i (lrclk_i),
      .wclk_i (wclk_i), .inv_bclk_i (inv_bclk_i), .trig_lr_i (trig_lr_i),
      .msb_late_i (msb_late_i), .mute_i (mute_i), .ovlp_i (ovlp_i),
      .smp_valid_i (smp_valid_i), .smp_ready_o (smp_ready_o),
      .smp_left_i (smp_left_i), .smp_right_i (smp_right_i),
      .sdata_o (sdata_o), .mute_stat_o (mute_stat_o)
   );

   int nt = 0, nf = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nt++;
      if (!ok) begin
         nf++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   // Expected bit for slot position j relative to the word start (R5, R6)
   function automatic bit exp_bit(input logic [W-1:0] d, input bit late, input int j);
      if (j < 0) return 1'b0;
      if (late) begin
         if (j == 0)     return 1'b0;
         if (j - 1 < W)  return d[W-j];
         return 1'b0;
      end
      if (j < W) return d[W-1-j];
      return 1'b0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nf++; nt++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", nt, nf);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] a_l, a_r, p_l, p_r, d;
      bit p_v, c_pol, c_trig, c_dly, n_pol, n_trig, n_dly;
      bit push, m_on, m_mid, prev_exp, prev_pol, have_prev, e, nopush_prev, chg;
      string tag;
      void'($urandom(32'd2024));
      a_l = '0; a_r = '0; p_l = '0; p_r = '0; p_v = 0;
      c_pol = 0; c_trig = 1; c_dly = 0;
      have_prev = 0; prev_exp = 0; prev_pol = 0; nopush_prev = 0;

      // R1: reset state
      repeat (5) @(negedge clk);
      chk(sdata_o == 0, "R1", sdata_o, 0);
      chk(smp_ready_o == 1, "R1", smp_ready_o, 1);
      chk(mute_stat_o == 0, "R1", mute_stat_o, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sdata_o == 0, "R1", sdata_o, 0);
      chk(smp_ready_o == 1, "R1", smp_ready_o, 1);

      for (int f = 0; f < NF; f++) begin
         // R9/R10: a held pair becomes active at the frame start, else repeat
         if (p_v) begin a_l = p_l; a_r = p_r; p_v = 0; end
         push  = (f == 4) ? 0 : (f < 6) ? 1 : bit'($urandom % 2);
         m_on  = (f == 3) ? 1 : (f < 6) ? 0 : (($urandom % 5) == 0);
         m_mid = bit'($urandom % 2);
         case (f)
            0: begin n_pol = 0; n_trig = 1; n_dly = 1; end
            1: begin n_pol = 0; n_trig = 0; n_dly = 0; end
            2: begin n_pol = 1; n_trig = 1; n_dly = 0; end
            3: begin n_pol = 1; n_trig = 0; n_dly = 1; end
            4: begin n_pol = 0; n_trig = 1; n_dly = 0; end
            default: begin
               n_pol = bit'($urandom % 2); n_trig = bit'($urandom % 2); n_dly = bit'($urandom % 2);
            end
         endcase
         chg = (n_pol != c_pol) || (n_trig != c_trig) || (n_dly != c_dly);
         for (int half = 0; half < 2; half++) begin
            for (int k = 0; k < SLOT; k++) begin
               // rising-edge launch: previous bit captured at this falling edge
               if (have_prev && prev_pol)
                  chk(sdata_o == prev_exp, tag, sdata_o, prev_exp);
               bclk_i = 1'b0;
               if (k == 0) lrclk_i = (half == 0);           // R6 left while high
               wclk_i = (k == WOFS);                         // R3 ignored / R4 used
               mute_i = m_on && !(m_mid && half == 1 && k >= 8);
               ovlp_i = bit'($urandom % 2);
               if (half == 1 && k == 10) begin               // R11 mid-frame change
                  inv_bclk_i = n_pol; trig_lr_i = n_trig; msb_late_i = n_dly;
               end
               d = (half == 0) ? a_l : a_r;
               e = mute_i ? 1'b0 : exp_bit(d, c_dly, k - (c_trig ? 0 : WOFS));
               if (mute_i)                         tag = "R7";
               else if (chg && half == 1 && k > 10) tag = "R11";
               else if (c_dly)                     tag = "R5";
               else if (!c_trig)                   tag = "R4";
               else if (c_pol)                     tag = "R2";
               else if (nopush_prev)               tag = "R10";
               else                                tag = "R3";
               if (half == 0 && k == 5 && push) begin
                  smp_valid_i = 1'b1;
                  smp_left_i  = (f == 0) ? 16'h8001 : 16'($urandom);
                  smp_right_i = (f == 0) ? 16'h7FFE : 16'($urandom);
                  p_l = smp_left_i; p_r = smp_right_i; p_v = 1;
               end
               if (half == 0 && k == 9 && push) begin       // R9 ignored while not ready
                  smp_valid_i = 1'b1;
                  smp_left_i  = 16'hFFFF; smp_right_i = 16'hFFFF;
               end
               @(negedge clk);
               smp_valid_i = 1'b0;
               repeat (H - 1) @(negedge clk);
               if (!c_pol) chk(sdata_o == e, tag, sdata_o, e);
               chk(mute_stat_o == ovlp_i, "R8", mute_stat_o, ovlp_i);
               if (half == 0 && k == 4) chk(smp_ready_o == 1, "R9", smp_ready_o, 1);
               if (half == 0 && k == 6) chk(smp_ready_o == !push, "R9", smp_ready_o, !push);
               bclk_i = 1'b1;
               repeat (H) @(negedge clk);
               prev_exp = e; prev_pol = c_pol; have_prev = 1;
            end
         end
         nopush_prev = !push;
         c_pol = n_pol; c_trig = n_trig; c_dly = n_dly;
      end
      if (have_prev && prev_pol) chk(sdata_o == prev_exp, tag, sdata_o, prev_exp);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nt, nf);
      $finish;
   end
endmodule